// File: doc/BRIEF.md
# Nonvolatile Restore and Store Sequencer

This block owns two 10-bit wiper registers and the nonvolatile words that back them. It also owns a small user constant memory. The nonvolatile cells are modelled as plain registers that come out of reset holding the never-programmed value, midscale (512). A decoded command arrives as a single-cycle strobe with a code, an address and a data word. The block then copies a wiper into its backing word, reloads a wiper from its backing word, writes a wiper directly, moves a byte in or out of the user memory, or reads back a backing word.

Each nonvolatile operation occupies the block for a time set per command class. Stores and user writes are the slowest, restores are shorter, and readbacks are shorter still. While an operation runs, the ready output is low. A hardware preset input reloads both wipers from their backing words when it returns high. The power-on restore uses the same busy window as a preset.

A write-protect input, active low, blocks every command that would change stored state. Restores and reads still run while it is low.

Top module: `nvm_wiper_seq`

## Requirements
- R1: After reset is released, both wipers read 512, the read data is 0, the error flag is 0, and ready stays low for exactly T_PRESET clock cycles (the power-on restore).
- R2: Code 4 loads cmd_data into the wiper chosen by cmd_addr[0] (0 selects wiper0, 1 selects wiper1). The new value is visible one cycle after the strobe, and ready does not drop.
- R3: Code 2 copies the chosen wiper into its backing word, and ready is low for T_STORE cycles.
- R4: Code 1 reloads the chosen wiper from its backing word. Code 8 reloads both wipers. Either one holds ready low for T_RESTORE cycles.
- R5: Code 10 places the chosen backing word on rd_data, and code 9 places the addressed user byte on rd_data, zero-extended. Both hold ready low for T_READ cycles.
- R6: Code 3 writes cmd_data[7:0] into user byte cmd_addr, for addresses 0 to 25, and holds ready low for T_STORE cycles.
- R7: A user address of 26 or above is out of range. A write to it changes no byte but still takes T_STORE cycles, and a read from it returns 0.
- R8: While wp_n is low, codes 2, 3 and 4 have no effect and ready stays high. Codes 1, 8, 9 and 10 behave as usual.
- R9: While preset_n is low, ready is low. On its return high, both wipers reload from their backing words and ready stays low for T_PRESET cycles.
- R10: A strobe that arrives while ready is low is discarded and sets cmd_err. cmd_err stays set until reset.
- R11: Codes other than 1, 2, 3, 4, 8, 9 and 10 change nothing, keep ready high and leave cmd_err clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, acts as power-on |
| cmd_valid | input | 1 | Single-cycle command strobe |
| cmd_code | input | 4 | Command code |
| cmd_addr | input | ADDR_W | Channel select (bit 0) or user byte address |
| cmd_data | input | WIPER_W | Wiper value or user byte (low bits) |
| preset_n | input | 1 | Preset, low holds off; reload on return high |
| wp_n | input | 1 | Write protect, active low |
| wiper0 | output | WIPER_W | Wiper 0 value |
| wiper1 | output | WIPER_W | Wiper 1 value |
| ready | output | 1 | High when idle and able to take a command |
| rd_data | output | WIPER_W | Result of the last readback command |
| cmd_err | output | 1 | Sticky flag for discarded commands |

## Verification
Every effect of an accepted strobe, whether on a wiper, a backing word or rd_data, is registered on the accepting edge, so it is visible at the falling edge that follows. Ready drops after that same edge and returns high after exactly the command's duration. The bench applies each strobe at a falling edge. It then counts the falling edges at which ready is low and compares that count with the duration the command class calls for. For a preset, counting starts at the first falling edge after preset_n rises, because the rise is sampled on the next rising edge. All values are compared only after ready is back high.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

   // Command codes; the restore codes 1 and 8 stay usable under write protect.
   typedef enum logic [3:0] {
      OP_NOP         = 4'd0,
      OP_RESTORE_ONE = 4'd1,
      OP_STORE_ONE   = 4'd2,
      OP_USER_WR     = 4'd3,
      OP_WIPER_WR    = 4'd4,
      OP_RESTORE_ALL = 4'd8,
      OP_USER_RD     = 4'd9,
      OP_NV_RD       = 4'd10
   } op_e;

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/nvs_busy_timer.sv
module nvs_busy_timer #(
   parameter int CNT_W      = 8,
   parameter int RESET_LOAD = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             busy
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= CNT_W'(RESET_LOAD);
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - CNT_W'(1);
   end

   assign busy = (cnt_q != '0);

   // R3 R4 R5: the busy window drains one step per cycle
   a_r3_countdown: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q != '0 && !load) |=> cnt_q == $past(cnt_q) - CNT_W'(1));

   a_r4_load_makes_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (load && load_val != '0) |=> busy);

endmodule

// File: rtl/nvs_user_mem.sv
module nvs_user_mem #(
   parameter int DEPTH = 26,
   parameter int AW    = 5,
   parameter int DW    = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);

   logic [DEPTH-1:0][DW-1:0] mem_q;
   logic                     in_range;

   assign in_range = (int'(addr) < DEPTH);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mem_q <= '0;
      else if (wr_en && in_range)
         mem_q[addr] <= wdata;
   end

   assign rdata = in_range ? mem_q[addr] : '0;

   // R7: an out-of-range write leaves every byte alone
   a_r7_oob_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !in_range) |=> $stable(mem_q));

   a_r6_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && in_range) |=> mem_q[$past(addr)] == $past(wdata));

endmodule

// File: rtl/nvm_wiper_seq.sv
module nvm_wiper_seq
   import nvs_pkg::*;
#(
   parameter int WIPER_W    = 10,
   parameter int ADDR_W     = 5,
   parameter int UMEM_DEPTH = 26,
   parameter int UBYTE_W    = 8,
   parameter int T_STORE    = 2000,
   parameter int T_RESTORE  = 100,
   parameter int T_READ     = 10,
   parameter int T_PRESET   = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_valid,
   input  logic [3:0]         cmd_code,
   input  logic [ADDR_W-1:0]  cmd_addr,
   input  logic [WIPER_W-1:0] cmd_data,
   input  logic               preset_n,
   input  logic               wp_n,
   output logic [WIPER_W-1:0] wiper0,
   output logic [WIPER_W-1:0] wiper1,
   output logic               ready,
   output logic [WIPER_W-1:0] rd_data,
   output logic               cmd_err
);

   localparam int NCH      = 2;
   localparam int MIDSCALE = 1 << (WIPER_W - 1);
   localparam int T_MAX    = max_of(max_of(T_STORE, T_RESTORE), max_of(T_READ, T_PRESET));
   localparam int CNT_W    = $clog2(T_MAX + 1);

   // elaboration checks
   if (UMEM_DEPTH > (1 << ADDR_W)) begin : g_bad_depth
      $error("user memory depth exceeds address range");
   end
   if (UBYTE_W > WIPER_W) begin : g_bad_byte
      $error("user byte wider than read data");
   end
   if (T_STORE < 1 || T_RESTORE < 1 || T_READ < 1 || T_PRESET < 1) begin : g_bad_time
      $error("every duration must be at least one cycle");
   end

   logic                            pr_q;
   logic                            preset_rise;
   logic                            busy;
   logic                            accept;
   logic                            ch;
   logic                            ld_en;
   logic [CNT_W-1:0]                ld_val;
   logic                            do_restore_one, do_restore_all, do_store;
   logic                            do_wwr, do_uwr, do_urd, do_nvrd;
   logic [NCH-1:0][WIPER_W-1:0]     wip_vec, nv_vec;
   logic [UBYTE_W-1:0]              u_rdata;
   logic [WIPER_W-1:0]              rd_q;
   logic                            err_q;

   assign preset_rise = preset_n & ~pr_q;
   assign ready       = ~busy & pr_q;
   assign accept      = cmd_valid & ready;
   assign ch          = cmd_addr[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pr_q <= 1'b1;
      else        pr_q <= preset_n;
   end

   always_comb begin
      do_restore_one = 1'b0;
      do_restore_all = 1'b0;
      do_store       = 1'b0;
      do_wwr         = 1'b0;
      do_uwr         = 1'b0;
      do_urd         = 1'b0;
      do_nvrd        = 1'b0;
      ld_en          = 1'b0;
      ld_val         = '0;
      if (accept) begin
         case (cmd_code)
            OP_RESTORE_ONE: begin do_restore_one = 1'b1; ld_en = 1'b1; ld_val = CNT_W'(T_RESTORE); end
            OP_RESTORE_ALL: begin do_restore_all = 1'b1; ld_en = 1'b1; ld_val = CNT_W'(T_RESTORE); end
            OP_STORE_ONE:   if (wp_n) begin do_store = 1'b1; ld_en = 1'b1; ld_val = CNT_W'(T_STORE); end
            OP_USER_WR:     if (wp_n) begin do_uwr = 1'b1; ld_en = 1'b1; ld_val = CNT_W'(T_STORE); end
            OP_WIPER_WR:    if (wp_n) do_wwr = 1'b1;
            OP_USER_RD:     begin do_urd = 1'b1; ld_en = 1'b1; ld_val = CNT_W'(T_READ); end
            OP_NV_RD:       begin do_nvrd = 1'b1; ld_en = 1'b1; ld_val = CNT_W'(T_READ); end
            default: ;
         endcase
      end
      if (preset_rise) begin
         ld_en  = 1'b1;
         ld_val = CNT_W'(T_PRESET);
      end
   end

   nvs_busy_timer #(
      .CNT_W      (CNT_W),
      .RESET_LOAD (T_PRESET)
   ) i_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ld_en),
      .load_val (ld_val),
      .busy     (busy)
   );

   // per-channel wiper and backing word
   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic [WIPER_W-1:0] wip_r, nv_r;
      logic               sel;
      assign sel = (int'(ch) == c);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            wip_r <= WIPER_W'(MIDSCALE);
            nv_r  <= WIPER_W'(MIDSCALE);
         end else begin
            if (preset_rise || do_restore_all || (do_restore_one && sel))
               wip_r <= nv_r;
            else if (do_wwr && sel)
               wip_r <= cmd_data;
            if (do_store && sel)
               nv_r <= wip_r;
         end
      end

      assign wip_vec[c] = wip_r;
      assign nv_vec[c]  = nv_r;
   end

   nvs_user_mem #(
      .DEPTH (UMEM_DEPTH),
      .AW    (ADDR_W),
      .DW    (UBYTE_W)
   ) i_umem (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (do_uwr),
      .addr  (cmd_addr),
      .wdata (cmd_data[UBYTE_W-1:0]),
      .rdata (u_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q  <= '0;
         err_q <= 1'b0;
      end else begin
         if (do_urd)
            rd_q <= WIPER_W'(u_rdata);
         else if (do_nvrd)
            rd_q <= nv_vec[ch];
         if (cmd_valid && !ready)
            err_q <= 1'b1;
      end
   end

   assign wiper0  = wip_vec[0];
   assign wiper1  = wip_vec[1];
   assign rd_data = rd_q;
   assign cmd_err = err_q;

   // R8: protected strobes leave the backing words untouched
   a_r8_wp_keeps_nv: assert property (@(posedge clk) disable iff (!rst_n)
      (!wp_n && cmd_valid && ready) |=> $stable(nv_vec));

   a_r8_wp_keeps_wiper: assert property (@(posedge clk) disable iff (!rst_n)
      (!wp_n && cmd_valid && ready && cmd_code == OP_WIPER_WR) |=> $stable(wip_vec));

   // R10: a strobe while busy is dropped and flagged
   a_r10_discard: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !ready && pr_q) |=> ($stable(wip_vec) && $stable(nv_vec) && cmd_err));

   a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_err |=> cmd_err);

   // R9: preset rise reloads both wipers and opens a busy window
   a_r9_preset_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (preset_n && !pr_q) |=> (wip_vec == $past(nv_vec)) && !ready);

   // R4: restore of both channels
   a_r4_restore_all: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && ready && cmd_code == OP_RESTORE_ALL) |=> wip_vec == $past(nv_vec));

   // R2: direct wiper write never drops ready
   a_r2_write_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && ready && wp_n && cmd_code == OP_WIPER_WR) |=> ready);

endmodule

// File: tb/test_nvm_wiper_seq.sv
module test_nvm_wiper_seq;

   localparam int CLK_PERIOD = 10;
   localparam int TS = 20;
   localparam int TR = 8;
   localparam int TD = 3;
   localparam int TP = 5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_valid = 1'b0;
   logic [3:0] cmd_code = '0;
   logic [4:0] cmd_addr = '0;
   logic [9:0] cmd_data = '0;
   logic       preset_n = 1'b1;
   logic       wp_n = 1'b1;
   logic [9:0] wiper0, wiper1, rd_data;
   logic       ready, cmd_err;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   nvm_wiper_seq #(
      .T_STORE   (TS),
      .T_RESTORE (TR),
      .T_READ    (TD),
      .T_PRESET  (TP)
   ) i_nvm_wiper_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .cmd_code  (cmd_code),
      .cmd_addr  (cmd_addr),
      .cmd_data  (cmd_data),
      .preset_n  (preset_n),
      .wp_n      (wp_n),
      .wiper0    (wiper0),
      .wiper1    (wiper1),
      .ready     (ready),
      .rd_data   (rd_data),
      .cmd_err   (cmd_err)
   );

   typedef struct packed {
      logic [3:0] code;
      logic [4:0] addr;
      logic [9:0] data;
      logic       wp;
      logic [7:0] busy;
      logic [9:0] w0;
      logic [9:0] w1;
      logic [9:0] rd;
   } vec_t;

   localparam int NV = 26;
   localparam vec_t VEC [NV] = '{
      '{4'd4,  5'd0,  10'd100,  1'b1, 8'd0,  10'd100, 10'd512,  10'd0},   // R2
      '{4'd4,  5'd1,  10'd900,  1'b1, 8'd0,  10'd100, 10'd900,  10'd0},   // R2
      '{4'd2,  5'd0,  10'd0,    1'b1, 8'(TS), 10'd100, 10'd900, 10'd0},   // R3
      '{4'd4,  5'd0,  10'd7,    1'b1, 8'd0,  10'd7,   10'd900,  10'd0},
      '{4'd1,  5'd0,  10'd0,    1'b1, 8'(TR), 10'd100, 10'd900, 10'd0},   // R4
      '{4'd10, 5'd1,  10'd0,    1'b1, 8'(TD), 10'd100, 10'd900, 10'd512}, // R5
      '{4'd10, 5'd0,  10'd0,    1'b1, 8'(TD), 10'd100, 10'd900, 10'd100},
      '{4'd3,  5'd25, 10'h3A5,  1'b1, 8'(TS), 10'd100, 10'd900, 10'd100}, // R6
      '{4'd9,  5'd25, 10'd0,    1'b1, 8'(TD), 10'd100, 10'd900, 10'h0A5},
      '{4'd3,  5'd26, 10'h077,  1'b1, 8'(TS), 10'd100, 10'd900, 10'h0A5}, // R7
      '{4'd9,  5'd26, 10'd0,    1'b1, 8'(TD), 10'd100, 10'd900, 10'd0},
      '{4'd10, 5'd1,  10'd0,    1'b1, 8'(TD), 10'd100, 10'd900, 10'd512},
      '{4'd2,  5'd1,  10'd0,    1'b0, 8'd0,  10'd100, 10'd900,  10'd512}, // R8
      '{4'd4,  5'd1,  10'd5,    1'b0, 8'd0,  10'd100, 10'd900,  10'd512},
      '{4'd8,  5'd0,  10'd0,    1'b0, 8'(TR), 10'd100, 10'd512, 10'd512},
      '{4'd9,  5'd25, 10'd0,    1'b0, 8'(TD), 10'd100, 10'd512, 10'h0A5},
      '{4'd10, 5'd0,  10'd0,    1'b1, 8'(TD), 10'd100, 10'd512, 10'd100},
      '{4'd3,  5'd25, 10'h011,  1'b0, 8'd0,  10'd100, 10'd512,  10'd100},
      '{4'd9,  5'd25, 10'd0,    1'b1, 8'(TD), 10'd100, 10'd512, 10'h0A5},
      '{4'd5,  5'd0,  10'd3,    1'b1, 8'd0,  10'd100, 10'd512,  10'h0A5}, // R11
      '{4'd4,  5'd1,  10'd1023, 1'b1, 8'd0,  10'd100, 10'd1023, 10'h0A5},
      '{4'd2,  5'd1,  10'd0,    1'b1, 8'(TS), 10'd100, 10'd1023, 10'h0A5},
      '{4'd4,  5'd0,  10'd0,    1'b1, 8'd0,  10'd0,   10'd1023, 10'h0A5},
      '{4'd4,  5'd1,  10'd0,    1'b1, 8'd0,  10'd0,   10'd0,    10'h0A5},
      '{4'd8,  5'd0,  10'd0,    1'b1, 8'(TR), 10'd100, 10'd1023, 10'h0A5},
      '{4'd10, 5'd1,  10'd0,    1'b1, 8'(TD), 10'd100, 10'd1023, 10'd1023}
   };

   task automatic check(input string req, input string what, input int got, input int exp);
      tests++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
      end
   endtask

   task automatic wait_ready(output int n);
      n = 0;
      while (!ready) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic issue(input logic [3:0] c, input logic [4:0] a, input logic [9:0] d, input logic wp);
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_code  = c;
      cmd_addr  = a;
      cmd_data  = d;
      wp_n      = wp;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   initial begin
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      wait_ready(n);
      check("R1", "power-on busy cycles", n, TP);
      check("R1", "wiper0 after reset", int'(wiper0), 512);
      check("R1", "wiper1 after reset", int'(wiper1), 512);
      check("R1", "rd_data after reset", int'(rd_data), 0);
      check("R1", "cmd_err after reset", int'(cmd_err), 0);

      for (int i = 0; i < NV; i++) begin
         issue(VEC[i].code, VEC[i].addr, VEC[i].data, VEC[i].wp);
         wait_ready(n);
         check("vec", $sformatf("busy cycles #%0d", i), n, int'(VEC[i].busy));
         check("vec", $sformatf("wiper0 #%0d", i), int'(wiper0), int'(VEC[i].w0));
         check("vec", $sformatf("wiper1 #%0d", i), int'(wiper1), int'(VEC[i].w1));
         check("vec", $sformatf("rd_data #%0d", i), int'(rd_data), int'(VEC[i].rd));
      end
      wp_n = 1'b1;

      // R11: unknown code left the error flag clear
      check("R11", "cmd_err after unknown code", int'(cmd_err), 0);

      // R10: strobe during a store is discarded
      @(negedge clk);
      cmd_valid = 1'b1; cmd_code = 4'd2; cmd_addr = 5'd0; cmd_data = '0;
      @(negedge clk);
      cmd_code = 4'd4; cmd_data = 10'd55;
      @(negedge clk);
      cmd_valid = 1'b0;
      wait_ready(n);
      check("R10", "wiper0 after discarded write", int'(wiper0), 100);
      check("R10", "cmd_err set", int'(cmd_err), 1);
      issue(4'd0, 5'd0, 10'd0, 1'b1);
      check("R10", "cmd_err sticky", int'(cmd_err), 1);

      // R9: preset
      issue(4'd4, 5'd0, 10'd3, 1'b1);
      check("R2", "wiper0 direct write", int'(wiper0), 3);
      @(negedge clk);
      preset_n = 1'b0;
      @(negedge clk);
      check("R9", "ready low during preset", int'(ready), 0);
      issue(4'd4, 5'd1, 10'd9, 1'b1);
      check("R9", "wiper1 kept during preset", int'(wiper1), 1023);
      preset_n = 1'b1;
      @(negedge clk);
      wait_ready(n);
      check("R9", "preset busy cycles", n, TP);
      check("R9", "wiper0 reloaded", int'(wiper0), 100);
      check("R9", "wiper1 reloaded", int'(wiper1), 1023);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: got hang expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule